// File: doc/BRIEF.md
# Vacuum Fluorescent Display Scan Timer

This block produces the digit-scan timing for a multiplexed vacuum fluorescent display. Once started, it steps a one-hot digit strobe through a frame of 16 or 32 digits. Each digit is held for one display period: `period + 1` ticks of a prescaled clock, where a tick comes every 32 or every 128 system clocks. After the last digit of a frame, an optional blank interval of one to three display periods may follow, and then the frame wraps to digit 0.

Inside each digit time there are two fixed blanking points. The early point T1 is `period >> 2` and the late point T2 is `(3 * period) >> 2`. The block uses them in two ways. It cuts short the high-voltage strobes and a four-output low-voltage group. It also shapes a gradation data enable. An interrupt pulse marks either every digit start or the start of the blank interval.

The controller is a three-state machine:
- `ST_IDLE` is the stopped state.
- `ST_DIGIT` means a digit is being shown.
- `ST_BLANK` is the interval after the frame.

Its transitions are:
- start: `ST_IDLE` to `ST_DIGIT`.
- advance: `ST_DIGIT` to `ST_DIGIT` with the next digit.
- wrap: the last digit goes to digit 0 when the scan code is 0.
- enter-blank: `ST_DIGIT` to `ST_BLANK` when the scan code is not 0.
- leave-blank: `ST_BLANK` to `ST_DIGIT` at digit 0.
- stop: any state to `ST_IDLE`.

Software sets the block up through three byte-wide registers, using a write strobe and a read strobe.

Top module: `vfd_scan_timer`

## Requirements
- R1: After reset, all three registers read 0x00, all strobes are 0, irq is 0, grad_data is 0, and grp_out is 0.
- R2: The registers are laid out as follows.
  - Address 0 (mode): bit0 run, bits2:1 scan code, bit3 wide, bit4 gradation, bit5 slow.
  - Address 1 (control): bit0 invert, bit1 toff_kill, bit2 cmos_toff, bit3 hv_toff, bit4 grad_pol.
  - Address 2: the 8-bit period.
  - Unassigned bits read 0, address 3 reads 0, and rd_data is 0 while rd_en is low.
- R3: A mode write that takes the run bit from 0 to 1 starts the scan at digit 0 from the next cycle on. Writing run=1 while run is already 1 has no effect. Writing run=0 clears all strobes from the next cycle on.
- R4: Each digit lasts (period+1)*D clocks, where D is 32 when slow=0 and 128 when slow=1. Exactly one bit of dig_strobe is high during a digit, and it rises from bit 0 upward.
- R5: A frame holds 32 digits when wide=1 and gradation=0, and 16 digits otherwise.
- R6: When the scan code n is nonzero, all strobes stay 0 for n*(period+1)*D clocks after the last digit, and then digit 0 follows.
- R7: irq is a one-clock pulse.
  - With scan code 0, it falls in the first clock of every digit, including digit 0 after a start.
  - With a nonzero code, it falls only in the first clock of the blank interval.
- R8: hv_out equals dig_strobe, except that it is 0 for tick counts t >= T2 while hv_toff=1.
- R9: grp_out[i] is dig_strobe[i], for i from 0 to 3.
  - It is cleared for t >= T2 when cmos_toff=1 and toff_kill=0.
  - It is then XORed with invert, including while stopped.
- R10: With gradation=1 during a digit, grad_data is high for T1 <= t < T2 when grad_pol=0, and outside that window when grad_pol=1. Otherwise grad_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| dig_strobe | output | 32 | One-hot digit timing |
| hv_out | output | 32 | Digit strobes after high-voltage blanking |
| grp_out | output | 4 | Low four strobes after low-voltage blanking and inversion |
| grad_data | output | 1 | Gradation data enable |
| irq | output | 1 | Interrupt pulse |

## Verification
The scan is run with four directed setups and eight random ones. These cover every scan code, both prescale rates, both frame widths, and gradation with each polarity. Every cycle is compared against a position model, which derives the digit and tick count only from the cycle offset since start.

Runs with period 0 versus 3 separate a per-tick count from a per-clock count. Runs with codes 0 versus 1–3 separate per-digit interrupts from one interrupt per frame. Gradation runs with wide=1 show whether the 16-digit limit is applied. Random control bytes pair the Toff enables, the kill bit and inversion in combinations that single out each gate. A run=1 rewrite in mid-scan checks that a repeated set does not restart the frame.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DIGIT = 2'd1,
        ST_BLANK = 2'd2
    } scan_state_t;

    typedef struct packed {
        logic       slow;
        logic       grad;
        logic       wide;
        logic [1:0] scan;
        logic       run;
    } mode_t;

    typedef struct packed {
        logic grad_pol;
        logic hv_toff;
        logic cmos_toff;
        logic toff_kill;
        logic invert;
    } ctrl_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/vfd_scan_regs.sv
module vfd_scan_regs
    import vfd_scan_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output mode_t             mode,
    output ctrl_t             ctrl,
    output logic [PER_W-1:0]  period,
    output logic [REG_W-1:0]  rd_data,
    output logic              start_req,
    output logic              stop_req
);
    logic mode_wr;

    assign mode_wr   = wr_en && (wr_addr == ADDR_MODE);
    // run edge 0 -> 1 starts; any mode write with run=0 stops
    assign start_req = mode_wr && wr_data[0] && !mode.run;
    assign stop_req  = mode_wr && !wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= '0;
            ctrl   <= '0;
            period <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE:   mode   <= mode_t'(wr_data[MODE_W-1:0]);
                ADDR_CTRL:   ctrl   <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_PERIOD: period <= wr_data[PER_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                ADDR_MODE:   rd_data = {{(REG_W-MODE_W){1'b0}}, mode};
                ADDR_CTRL:   rd_data = {{(REG_W-CTRL_W){1'b0}}, ctrl};
                ADDR_PERIOD: rd_data = {{(REG_W-PER_W){1'b0}}, period};
                default:     rd_data = '0;
            endcase
        end
    end

    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode == mode_t'($past(wr_data[MODE_W-1:0]))));

    assert_unassigned_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_MODE) |-> (rd_data[REG_W-1:MODE_W] == '0));
endmodule

// File: rtl/vfd_scan_prescaler.sv
module vfd_scan_prescaler #(
    parameter int DIV_LO = 32,
    parameter int DIV_HI = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic slow,
    output logic tick
);
    localparam int PRE_W = $clog2(DIV_HI);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] limit;

    assign limit = slow ? PRE_W'(DIV_HI - 1) : PRE_W'(DIV_LO - 1);
    assign tick  = !clear && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || cnt >= limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/vfd_scan_fsm.sv
module vfd_scan_fsm
    import vfd_scan_pkg::*;
#(
    parameter int NUM_DIG    = 32,
    parameter int NARROW_DIG = 16,
    parameter int PER_W      = 8,
    localparam int DIG_W     = $clog2(NUM_DIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    input  logic [1:0]       scan_code,
    input  logic             frame_wide,
    output scan_state_t      state,
    output logic [DIG_W-1:0] digit,
    output logic [PER_W-1:0] tcnt,
    output logic             irq,
    output logic             digit_on
);
    localparam logic [DIG_W-1:0] LAST_WIDE   = DIG_W'(NUM_DIG - 1);
    localparam logic [DIG_W-1:0] LAST_NARROW = DIG_W'(NARROW_DIG - 1);

    scan_state_t      nxt_state;
    logic [DIG_W-1:0] nxt_digit;
    logic [DIG_W-1:0] last_digit;
    logic [PER_W-1:0] nxt_tcnt;
    logic [1:0]       scan_cnt;
    logic [1:0]       nxt_scan;
    logic             nxt_irq;
    logic             period_end;

    assign last_digit = frame_wide ? LAST_WIDE : LAST_NARROW;
    assign period_end = tick && (tcnt >= period);

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_digit = digit;
        nxt_tcnt  = tcnt;
        nxt_scan  = scan_cnt;
        nxt_irq   = 1'b0;
        if (stop_req) begin
            nxt_state = ST_IDLE;
            nxt_digit = '0;
            nxt_tcnt  = '0;
            nxt_scan  = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        nxt_state = ST_DIGIT;
                        nxt_digit = '0;
                        nxt_tcnt  = '0;
                        nxt_irq   = (scan_code == 2'd0);
                    end
                end
                ST_DIGIT: begin
                    if (period_end) begin
                        nxt_tcnt = '0;
                        if (digit >= last_digit) begin
                            nxt_irq = 1'b1;
                            if (scan_code == 2'd0) begin
                                nxt_digit = '0;
                            end else begin
                                nxt_state = ST_BLANK;
                                nxt_scan  = '0;
                            end
                        end else begin
                            nxt_digit = digit + 1'b1;
                            nxt_irq   = (scan_code == 2'd0);
                        end
                    end else if (tick) begin
                        nxt_tcnt = tcnt + 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (period_end) begin
                        nxt_tcnt = '0;
                        if ({1'b0, scan_cnt} + 3'd1 >= {1'b0, scan_code}) begin
                            nxt_state = ST_DIGIT;
                            nxt_digit = '0;
                        end else begin
                            nxt_scan = scan_cnt + 1'b1;
                        end
                    end else if (tick) begin
                        nxt_tcnt = tcnt + 1'b1;
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            digit    <= '0;
            tcnt     <= '0;
            scan_cnt <= '0;
            irq      <= 1'b0;
        end else begin
            state    <= nxt_state;
            digit    <= nxt_digit;
            tcnt     <= nxt_tcnt;
            scan_cnt <= nxt_scan;
            irq      <= nxt_irq;
        end
    end

    // outputs
    always_comb begin
        digit_on = (state == ST_DIGIT);
    end

    assert_stop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (state == ST_IDLE));

    assert_start_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_req && !stop_req) |=>
            (state == ST_DIGIT && digit == '0 && tcnt == '0));

    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIGIT && period_end && digit < last_digit && !stop_req) |=>
            (digit == DIG_W'($past(digit) + 1'b1)));

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/vfd_scan_outputs.sv
module vfd_scan_outputs
    import vfd_scan_pkg::*;
#(
    parameter int NUM_DIG = 32,
    parameter int PER_W   = 8,
    parameter int GRP_W   = 4,
    localparam int DIG_W  = $clog2(NUM_DIG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               digit_on,
    input  logic [DIG_W-1:0]   digit,
    input  logic [PER_W-1:0]   tcnt,
    input  logic [PER_W-1:0]   period,
    input  ctrl_t              ctrl,
    input  logic               grad_mode,
    output logic [NUM_DIG-1:0] dig_strobe,
    output logic [NUM_DIG-1:0] hv_out,
    output logic [GRP_W-1:0]   grp_out,
    output logic               grad_data
);
    logic [PER_W+1:0] triple;
    logic [PER_W+1:0] toff2;
    logic [PER_W-1:0] toff1;
    logic             late;
    logic             window;
    logic             hv_cut;
    logic             grp_cut;

    assign triple  = {2'b00, period} + {1'b0, period, 1'b0};
    assign toff2   = triple >> 2;
    assign toff1   = period >> 2;
    assign late    = ({2'b00, tcnt} >= toff2);
    assign window  = (tcnt >= toff1) && !late;
    assign hv_cut  = ctrl.hv_toff && late;
    assign grp_cut = ctrl.cmos_toff && !ctrl.toff_kill && late;

    for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
        assign dig_strobe[i] = digit_on && (digit == DIG_W'(i));
        assign hv_out[i]     = dig_strobe[i] && !hv_cut;
    end

    for (genvar g = 0; g < GRP_W; g++) begin : g_grp
        assign grp_out[g] = (dig_strobe[g] && !grp_cut) ^ ctrl.invert;
    end

    assign grad_data = grad_mode && digit_on && (ctrl.grad_pol ? !window : window);

    assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_strobe));

    assert_hv_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((hv_out & ~dig_strobe) == '0));

    assert_grad_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !digit_on |-> !grad_data);
endmodule

// File: rtl/vfd_scan_timer.sv
module vfd_scan_timer
    import vfd_scan_pkg::*;
#(
    parameter int NUM_DIG    = 32,
    parameter int NARROW_DIG = 16,
    parameter int PER_W      = 8,
    parameter int DIV_LO     = 32,
    parameter int DIV_HI     = 128,
    parameter int GRP_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               rd_en,
    input  logic [1:0]         rd_addr,
    output logic [7:0]         rd_data,
    output logic [NUM_DIG-1:0] dig_strobe,
    output logic [NUM_DIG-1:0] hv_out,
    output logic [GRP_W-1:0]   grp_out,
    output logic               grad_data,
    output logic               irq
);
    localparam int DIG_W = $clog2(NUM_DIG);

    mode_t            mode;
    ctrl_t            ctrl;
    logic [PER_W-1:0] period;
    logic             start_req;
    logic             stop_req;
    logic             tick;
    logic             pre_clear;
    scan_state_t      state;
    logic [DIG_W-1:0] digit;
    logic [PER_W-1:0] tcnt;
    logic             digit_on;

    assign pre_clear = start_req || (state == ST_IDLE);

    vfd_scan_regs #(.PER_W(PER_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .mode      (mode),
        .ctrl      (ctrl),
        .period    (period),
        .rd_data   (rd_data),
        .start_req (start_req),
        .stop_req  (stop_req)
    );

    vfd_scan_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pre_clear),
        .slow  (mode.slow),
        .tick  (tick)
    );

    vfd_scan_fsm #(.NUM_DIG(NUM_DIG), .NARROW_DIG(NARROW_DIG), .PER_W(PER_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .tick       (tick),
        .period     (period),
        .scan_code  (mode.scan),
        .frame_wide (mode.wide && !mode.grad),
        .state      (state),
        .digit      (digit),
        .tcnt       (tcnt),
        .irq        (irq),
        .digit_on   (digit_on)
    );

    vfd_scan_outputs #(.NUM_DIG(NUM_DIG), .PER_W(PER_W), .GRP_W(GRP_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .digit_on   (digit_on),
        .digit      (digit),
        .tcnt       (tcnt),
        .period     (period),
        .ctrl       (ctrl),
        .grad_mode  (mode.grad),
        .dig_strobe (dig_strobe),
        .hv_out     (hv_out),
        .grp_out    (grp_out),
        .grad_data  (grad_data)
    );

    assert_grad_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIGIT && mode.grad && $past(mode.grad) && $past(state) == ST_IDLE)
            |-> (digit < DIG_W'(NARROW_DIG)));
endmodule

// File: tb/test_vfd_scan_timer.sv
`timescale 1ns/1ps
module test_vfd_scan_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [1:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [31:0] dig_strobe;
    logic [31:0] hv_out;
    logic [3:0]  grp_out;
    logic        grad_data;
    logic        irq;

    always #2 clk = ~clk;

    vfd_scan_timer i_vfd_scan_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .dig_strobe(dig_strobe),
        .hv_out(hv_out), .grp_out(grp_out), .grad_data(grad_data), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // current configuration
    int P, D, N, code;
    bit gr, pol, hv_en, cm_en, kill, inv;

    // per-run mismatch accumulators: 0 strobe, 1 hv, 2 grp, 3 grad, 4 irq
    string       tags [5] = '{"R4", "R8", "R9", "R10", "R7"};
    logic [31:0] fa [5];
    logic [31:0] fe [5];
    int          fb [5];
    int          fc [5];

    task automatic check(input bit ok, input string req, input string msg,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, msg, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string req);
        rd_en = 1'b1; rd_addr = a;
        #1;
        check(rd_data == exp, req, $sformatf("read addr %0d", a), {24'd0, rd_data}, {24'd0, exp});
        rd_en = 1'b0;
    endtask

    // position model: digit and tick count from cycle offset since start
    function automatic void model(input int c, output logic [31:0] dig, output int t,
                                  output bit irq_e, output bit act);
        int dp, body, frame, r;
        dp = (P + 1) * D; body = N * dp; frame = (N + code) * dp; r = c % frame;
        if (r < body) begin
            act = 1'b1; dig = 32'h1 << (r / dp); t = (r % dp) / D;
            irq_e = (code == 0) ? ((r % dp) == 0) : 1'b0;
        end else begin
            act = 1'b0; dig = '0; t = ((r - body) % dp) / D;
            irq_e = (r == body);
        end
    endfunction

    task automatic note(input int k, input logic [31:0] a, input logic [31:0] e, input int c);
        if (a !== e) begin
            if (fb[k] == 0) begin fa[k] = a; fe[k] = e; fc[k] = c; end
            fb[k]++;
        end
    endtask

    task automatic compare(input int c);
        logic [31:0] dig, hv_e;
        logic [3:0]  grp_e;
        int t, t1, t2;
        bit irq_e, act, win, grad_e;
        model(c, dig, t, irq_e, act);
        t1 = P / 4; t2 = (3 * P) / 4;
        hv_e   = (hv_en && t >= t2) ? 32'd0 : dig;
        grp_e  = ((cm_en && !kill && t >= t2) ? 4'd0 : dig[3:0]) ^ {4{inv}};
        win    = (t >= t1) && (t < t2);
        grad_e = gr && act && (pol ? !win : win);
        note(0, dig_strobe, dig, c);
        note(1, hv_out, hv_e, c);
        note(2, {28'd0, grp_out}, {28'd0, grp_e}, c);
        note(3, {31'd0, grad_data}, {31'd0, grad_e}, c);
        note(4, {31'd0, irq}, {31'd0, irq_e}, c);
    endtask

    task automatic run_cfg(input int p, input bit slow, input bit wide, input bit g,
                           input int cd, input logic [4:0] cv, input int rw);
        logic [7:0] mv;
        int dp, body, frame, total;
        P = p; D = slow ? 128 : 32; N = (wide && !g) ? 32 : 16; code = cd; gr = g;
        inv = cv[0]; kill = cv[1]; cm_en = cv[2]; hv_en = cv[3]; pol = cv[4];
        mv = {2'b00, slow, g, wide, 2'(cd), 1'b0};
        wr(2'd2, 8'(p));
        wr(2'd1, {3'b000, cv});
        wr(2'd0, mv);
        wr(2'd0, mv | 8'h01);      // run 0 -> 1: start (R3)
        for (int k = 0; k < 5; k++) begin fb[k] = 0; fa[k] = '0; fe[k] = '0; fc[k] = 0; end
        dp = (P + 1) * D; body = N * dp; frame = (N + code) * dp; total = frame + 2 * dp + 4;
        for (int c = 0; c < total; c++) begin
            compare(c);
            if (c == body - 1)
                check(dig_strobe == (32'h1 << (N - 1)), "R5", "last digit of frame", dig_strobe, 32'h1 << (N - 1));
            if (c == body)
                check(dig_strobe == ((code == 0) ? 32'h1 : 32'h0), "R6", "first cycle after last digit",
                      dig_strobe, (code == 0) ? 32'h1 : 32'h0);
            if (c == frame && code != 0)
                check(dig_strobe == 32'h1, "R6", "wrap after blank interval", dig_strobe, 32'h1);
            // rewrite run=1 while running: must not restart (R3)
            if (c == rw) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = mv | 8'h01; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int k = 0; k < 5; k++)
            check(fb[k] == 0, tags[k], $sformatf("%0d mismatches p=%0d D=%0d N=%0d code=%0d ctrl=%b first at c=%0d",
                  fb[k], P, D, N, code, cv, fc[k]), fa[k], fe[k]);
        wr(2'd0, mv);               // stop (R3)
        check(dig_strobe == 0 && hv_out == 0 && !grad_data && !irq, "R3", "stopped outputs",
              {dig_strobe[30:0], grad_data}, 32'd0);
        check(grp_out == {4{inv}}, "R9", "group level while stopped", {28'd0, grp_out}, {28'd0, {4{inv}}});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd715));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dig_strobe == 0 && hv_out == 0 && grp_out == 0 && !grad_data && !irq, "R1",
              "outputs in reset", {dig_strobe[27:0], grp_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check(2'd0, 8'h00, "R1");
        rd_check(2'd1, 8'h00, "R1");
        rd_check(2'd2, 8'h00, "R1");
        // R2: layout and unassigned bits; run stays 0 so no scan (R3)
        wr(2'd0, 8'hFE);
        rd_check(2'd0, 8'h3E, "R2");
        wr(2'd1, 8'hFF);
        rd_check(2'd1, 8'h1F, "R2");
        wr(2'd2, 8'hA5);
        rd_check(2'd2, 8'hA5, "R2");
        rd_check(2'd3, 8'h00, "R2");
        rd_en = 1'b0; rd_addr = 2'd2; #1;
        check(rd_data == 0, "R2", "rd_en low", {24'd0, rd_data}, 32'd0);
        repeat (40) @(negedge clk);
        check(dig_strobe == 0, "R3", "no scan without run edge", dig_strobe, 32'd0);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);

        // directed corners
        run_cfg(0, 1'b0, 1'b0, 1'b0, 0, 5'b00000, 50);   // period 0, irq every digit
        run_cfg(3, 1'b0, 1'b1, 1'b0, 3, 5'b01100, 300);  // wide frame, 3-period blank, Toff
        run_cfg(2, 1'b0, 1'b1, 1'b1, 2, 5'b00111, 90);   // gradation forces 16, kill + invert
        run_cfg(3, 1'b1, 1'b0, 1'b1, 1, 5'b11001, 700);  // slow prescale, reversed gradation

        // constrained random
        for (int i = 0; i < 8; i++) begin
            int p, cd, rw;
            bit sl, wd, g;
            logic [4:0] cv;
            p  = $urandom_range(0, 3);
            sl = ($urandom_range(0, 3) == 0);
            wd = sl ? 1'b0 : 1'($urandom_range(0, 1));
            cd = sl ? $urandom_range(0, 1) : $urandom_range(0, 3);
            g  = 1'($urandom_range(0, 1));
            cv = 5'($urandom_range(0, 31));
            rw = $urandom_range(10, 200);
            run_cfg(p, sl, wd, g, cd, cv, rw);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule